// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath of a 32-bit core that runs each instruction over several short cycles. One ALU and one memory port handle both instruction fetch and data access. Internal registers hold values from one cycle to the next: the program counter, an instruction register, a memory data register, two operand latches, an ALU result latch, a saved exception PC and a one-bit cause flag. A 32-entry register file, with two read ports and one write port, holds the architectural registers. An external control sequencer drives every multiplexer select and every write enable, one cycle at a time. The datapath sends back the opcode and function fields, the ALU zero flag and a signed-overflow flag.

The sequencer usually steps through these phases: FETCH, DECODE, then EXEC, MEM or BRANCH/JUMP, then WRITEBACK, plus an EXCEPTION step. In FETCH the instruction is read at the PC and the PC advances by four through the ALU. In DECODE both source registers are latched and a branch target is computed whatever the instruction turns out to be. In EXEC the ALU forms a load/store address or an R-type result. MEM moves data between the memory port and the data latches. WRITEBACK retires a result into the register file. BRANCH and JUMP load the PC. EXCEPTION saves PC-4 and a cause, then redirects the PC to a fixed vector. The memory responds combinationally to the address during the cycle, and it writes at the clock edge under its own enable.

Top module: `mc_datapath`

## Requirements
- R1: While rst_n is low, the PC, the saved exception PC and the cause flag are zero.
- R2: When ir_we is high, the instruction register loads mem_rdata at the edge. opcode shows IR[31:26] and funct shows IR[5:0]. With a_sel=0, b_sel=1, alu_op=010, pc_sel=0 and pc_we=1, the PC becomes PC+4.
- R3: The A and B latches load on every edge from the registers named by IR[25:21] and IR[20:16]. The ALU result latch also loads on every edge. With a_sel=0 and b_sel=3 it therefore holds PC + (sign-extended IR[15:0] shifted left by 2).
- R4: mem_addr is the ALU result latch when addr_from_alu=1 and the PC when it is 0. mem_wdata is the B latch. The memory data register loads mem_rdata on every edge.
- R5: When rf_we=1 the register file writes at the edge. The destination is IR[15:11] if rf_dst_rd=1 and IR[20:16] if it is 0. The data is the memory data register if rf_from_mdr=1 and the ALU result latch if it is 0.
- R6: Register 0 always reads zero, and a write to it has no effect.
- R7: ALU codes: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed set-less-than (result 1 or 0). Any other code gives 0. alu_zero is high exactly when the result is zero.
- R8: alu_ovf is high when a signed add or subtract falls outside the 32-bit two's-complement range. For all other codes it is low.
- R9: First operand: 0 selects the PC, 1 selects the A latch. Second operand: 0 selects the B latch, 1 the constant 4, 2 the sign-extended IR[15:0], 3 that value shifted left by 2.
- R10: PC source: 0 selects the live ALU result, 1 the ALU result latch, 2 {PC[31:28], IR[25:0], 00}, 3 the vector 0x0C000000.
- R11: The PC loads when pc_we=1, or when pc_cond_we=1 and alu_zero=1. Otherwise it holds its value.
- R12: When epc_we=1 the saved exception PC loads the live ALU result. When cause_we=1 the cause flag loads cause_val. Each holds its value when its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Store data (B latch) |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| addr_from_alu | input | 1 | Address select: 1 = ALU result latch, 0 = PC |
| ir_we | input | 1 | Instruction register load |
| a_sel | input | 1 | ALU first-operand select |
| b_sel | input | 2 | ALU second-operand select |
| alu_op | input | 3 | ALU function code |
| pc_sel | input | 2 | PC source select |
| pc_we | input | 1 | Unconditional PC write |
| pc_cond_we | input | 1 | PC write qualified by alu_zero |
| rf_we | input | 1 | Register file write |
| rf_dst_rd | input | 1 | Destination field select |
| rf_from_mdr | input | 1 | Write data select |
| epc_we | input | 1 | Saved exception PC load |
| cause_we | input | 1 | Cause flag load |
| cause_val | input | 1 | Cause value to record |
| opcode | output | 6 | IR[31:26] for the sequencer |
| funct | output | 6 | IR[5:0] for the sequencer |
| alu_zero | output | 1 | ALU result is zero |
| alu_ovf | output | 1 | Signed overflow of add or subtract |
| pc_q | output | 32 | Current PC |
| epc_q | output | 32 | Saved exception PC |
| cause_q | output | 1 | Recorded exception cause |

## Verification
The assertions assume the sequencer drives legal select codes. They also assume that a fetch step uses exactly the PC, constant-four, add and ALU-source pattern, and that no other step writes the PC with that same pattern. The bench respects this because every cycle starts from an all-zero control word and sets only the fields of one named step: fetch, decode, immediate or register execute, memory read or write, writeback, branch, jump or exception. The register-file contents are observed only through the B latch on mem_wdata after a decode step, and the ALU result latch only through mem_addr, sampled before the following edge.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic {
        OPA_PC  = 1'b0,
        OPA_REG = 1'b1
    } opa_sel_e;

    typedef enum logic [1:0] {
        OPB_REG   = 2'd0,
        OPB_FOUR  = 2'd1,
        OPB_IMM   = 2'd2,
        OPB_IMMSH = 2'd3
    } opb_sel_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'd0,
        PCS_ALUOUT = 2'd1,
        PCS_JUMP   = 2'd2,
        PCS_VECTOR = 2'd3
    } pc_sel_e;

endpackage

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [2:0]   op,
    output logic [W-1:0] res,
    output logic         zero,
    output logic         ovf
);
    import mc_pkg::*;

    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic         lt;

    assign sum  = opa + opb;
    assign diff = opa - opb;
    assign lt   = $signed(opa) < $signed(opb);

    always_comb begin
        res = '0;
        ovf = 1'b0;
        case (alu_op_e'(op))
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_ADD: begin
                res = sum;
                ovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
            end
            ALU_SUB: begin
                res = diff;
                ovf = (opa[W-1] != opb[W-1]) && (diff[W-1] != opa[W-1]);
            end
            ALU_SLT: res = {{(W-1){1'b0}}, lt};
            default: res = '0;
        endcase
    end

    assign zero = (res == '0);

endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic [$clog2(NREG)-1:0] ra1,
    input  logic [$clog2(NREG)-1:0] ra2,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [W-1:0]            wd,
    input  logic                    we,
    output logic [W-1:0]            rd1,
    output logic [W-1:0]            rd2
);
    localparam int AW = $clog2(NREG);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && (wa != AW'(0))) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == AW'(0)) ? '0 : regs[ra1];
    assign rd2 = (ra2 == AW'(0)) ? '0 : regs[ra2];

endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath #(
    parameter int          XLEN    = 32,
    parameter int          NREG    = 32,
    parameter logic [31:0] EXC_VEC = 32'h0C00_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            addr_from_alu,
    input  logic            ir_we,
    input  logic            a_sel,
    input  logic [1:0]      b_sel,
    input  logic [2:0]      alu_op,
    input  logic [1:0]      pc_sel,
    input  logic            pc_we,
    input  logic            pc_cond_we,
    input  logic            rf_we,
    input  logic            rf_dst_rd,
    input  logic            rf_from_mdr,
    input  logic            epc_we,
    input  logic            cause_we,
    input  logic            cause_val,
    output logic [5:0]      opcode,
    output logic [5:0]      funct,
    output logic            alu_zero,
    output logic            alu_ovf,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] epc_q,
    output logic            cause_q
);
    import mc_pkg::*;

    localparam int RAW  = $clog2(NREG);
    localparam int IMMW = 16;
    localparam int JW   = 26;

    logic [XLEN-1:0] pc_r, ir_r, mdr_r, a_r, b_r, aluout_r, epc_r;
    logic            cause_r;
    logic [XLEN-1:0] imm_sx, imm_sh, opa, opb, alu_res, pc_next;
    logic [XLEN-1:0] rs_val, rt_val, rf_wd;
    logic [RAW-1:0]  rf_wa;
    logic            pc_load;

    assign imm_sx = {{(XLEN-IMMW){ir_r[IMMW-1]}}, ir_r[IMMW-1:0]};
    assign imm_sh = imm_sx << 2;

    // Operand multiplexers
    always_comb begin
        unique case (opa_sel_e'(a_sel))
            OPA_PC:  opa = pc_r;
            OPA_REG: opa = a_r;
        endcase
    end

    always_comb begin
        unique case (opb_sel_e'(b_sel))
            OPB_REG:   opb = b_r;
            OPB_FOUR:  opb = XLEN'(4);
            OPB_IMM:   opb = imm_sx;
            OPB_IMMSH: opb = imm_sh;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .opa  (opa),
        .opb  (opb),
        .op   (alu_op),
        .res  (alu_res),
        .zero (alu_zero),
        .ovf  (alu_ovf)
    );

    // PC source selection
    always_comb begin
        unique case (pc_sel_e'(pc_sel))
            PCS_ALU:    pc_next = alu_res;
            PCS_ALUOUT: pc_next = aluout_r;
            PCS_JUMP:   pc_next = {pc_r[XLEN-1:JW+2], ir_r[JW-1:0], 2'b00};
            PCS_VECTOR: pc_next = XLEN'(EXC_VEC);
        endcase
    end

    assign pc_load = pc_we | (pc_cond_we & alu_zero);

    assign rf_wa = rf_dst_rd ? ir_r[11 +: RAW] : ir_r[16 +: RAW];
    assign rf_wd = rf_from_mdr ? mdr_r : aluout_r;

    mc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk (clk),
        .ra1 (ir_r[21 +: RAW]),
        .ra2 (ir_r[16 +: RAW]),
        .wa  (rf_wa),
        .wd  (rf_wd),
        .we  (rf_we),
        .rd1 (rs_val),
        .rd2 (rt_val)
    );

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_r     <= '0;
            ir_r     <= '0;
            mdr_r    <= '0;
            a_r      <= '0;
            b_r      <= '0;
            aluout_r <= '0;
            epc_r    <= '0;
            cause_r  <= 1'b0;
        end else begin
            if (pc_load)  pc_r    <= pc_next;
            if (ir_we)    ir_r    <= mem_rdata;
            if (epc_we)   epc_r   <= alu_res;
            if (cause_we) cause_r <= cause_val;
            mdr_r    <= mem_rdata;
            a_r      <= rs_val;
            b_r      <= rt_val;
            aluout_r <= alu_res;
        end
    end

    // Output process
    always_comb begin
        mem_addr  = addr_from_alu ? aluout_r : pc_r;
        mem_wdata = b_r;
        opcode    = ir_r[31:26];
        funct     = ir_r[5:0];
        pc_q      = pc_r;
        epc_q     = epc_r;
        cause_q   = cause_r;
    end

endmodule

// File: rtl/mc_datapath_chk.sv
`timescale 1ns/1ps
module mc_datapath_chk #(
    parameter int          XLEN    = 32,
    parameter logic [31:0] EXC_VEC = 32'h0C00_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pc_we,
    input logic            pc_cond_we,
    input logic [1:0]      pc_sel,
    input logic            a_sel,
    input logic [1:0]      b_sel,
    input logic [2:0]      alu_op,
    input logic            alu_zero,
    input logic            epc_we,
    input logic            cause_we,
    input logic            cause_val,
    input logic [XLEN-1:0] pc_q,
    input logic [XLEN-1:0] epc_q,
    input logic            cause_q
);

    a_r2_fetch_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_sel == 2'd0 && !a_sel && b_sel == 2'd1 && alu_op == 3'b010)
        |=> pc_q == $past(pc_q) + XLEN'(4));

    a_r11_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_we && !pc_cond_we) |=> $stable(pc_q));

    a_r11_branch_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_we && pc_cond_we && !alu_zero) |=> $stable(pc_q));

    a_r10_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_sel == 2'd3) |=> pc_q == XLEN'(EXC_VEC));

    a_r10_jump_region: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_sel == 2'd2)
        |=> (pc_q[XLEN-1 -: 4] == $past(pc_q[XLEN-1 -: 4])) && (pc_q[1:0] == 2'b00));

    a_r12_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !epc_we |=> $stable(epc_q));

    a_r12_cause_load: assert property (@(posedge clk) disable iff (!rst_n)
        cause_we |=> cause_q == $past(cause_val));

    a_r12_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_we |=> $stable(cause_q));

endmodule

bind mc_datapath mc_datapath_chk #(.XLEN(XLEN), .EXC_VEC(EXC_VEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_we      (pc_we),
    .pc_cond_we (pc_cond_we),
    .pc_sel     (pc_sel),
    .a_sel      (a_sel),
    .b_sel      (b_sel),
    .alu_op     (alu_op),
    .alu_zero   (alu_zero),
    .epc_we     (epc_we),
    .cause_we   (cause_we),
    .cause_val  (cause_val),
    .pc_q       (pc_q),
    .epc_q      (epc_q),
    .cause_q    (cause_q)
);

// File: tb/tb_mc_datapath.sv
`timescale 1ns/1ps
module tb_mc_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        addr_from_alu, ir_we, a_sel, pc_we, pc_cond_we;
    logic [1:0]  b_sel, pc_sel;
    logic [2:0]  alu_op;
    logic        rf_we, rf_dst_rd, rf_from_mdr, epc_we, cause_we, cause_val;
    logic [5:0]  opcode, funct;
    logic        alu_zero, alu_ovf, cause_q;
    logic [31:0] pc_q, epc_q;

    logic [31:0] mem [0:1023];
    logic        bmem_we = 1'b0;
    logic [31:0] regm [0:15];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    mc_datapath dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .addr_from_alu(addr_from_alu), .ir_we(ir_we),
        .a_sel(a_sel), .b_sel(b_sel), .alu_op(alu_op), .pc_sel(pc_sel),
        .pc_we(pc_we), .pc_cond_we(pc_cond_we), .rf_we(rf_we),
        .rf_dst_rd(rf_dst_rd), .rf_from_mdr(rf_from_mdr), .epc_we(epc_we),
        .cause_we(cause_we), .cause_val(cause_val), .opcode(opcode),
        .funct(funct), .alu_zero(alu_zero), .alu_ovf(alu_ovf), .pc_q(pc_q),
        .epc_q(epc_q), .cause_q(cause_q)
    );

    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) if (bmem_we) mem[mem_addr[11:2]] <= mem_wdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd);
        return {6'd0, rs, rt, rd, 5'd0, 6'h20};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] ref_res(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b);
        case (op)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b010:  return a + b;
            3'b110:  return a - b;
            3'b111:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic ref_ovf(input logic [2:0] op, input logic [31:0] a,
                                     input logic [31:0] b);
        longint s;
        if (op == 3'b010)      s = longint'($signed(a)) + longint'($signed(b));
        else if (op == 3'b110) s = longint'($signed(a)) - longint'($signed(b));
        else return 1'b0;
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    task automatic idle();
        addr_from_alu = 0; ir_we = 0; a_sel = 0; b_sel = 0; alu_op = 0; pc_sel = 0;
        pc_we = 0; pc_cond_we = 0; rf_we = 0; rf_dst_rd = 0; rf_from_mdr = 0;
        epc_we = 0; cause_we = 0; cause_val = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fetch(input logic [31:0] instr);
        mem[pc_q[11:2]] = instr;
        idle(); ir_we = 1; b_sel = 1; alu_op = 3'b010; pc_we = 1;
        tick();
    endtask

    task automatic decode();
        idle(); b_sel = 3; alu_op = 3'b010;
        tick();
    endtask

    task automatic exec_imm();
        idle(); a_sel = 1; b_sel = 2; alu_op = 3'b010;
        tick();
    endtask

    task automatic writeback(input logic to_rd, input logic from_mdr);
        idle(); rf_we = 1; rf_dst_rd = to_rd; rf_from_mdr = from_mdr;
        tick();
    endtask

    task automatic peek_aluout(output logic [31:0] v);
        idle(); addr_from_alu = 1;
        #1 v = mem_addr;
        addr_from_alu = 0;
    endtask

    task automatic read_reg(input logic [4:0] k, input logic [31:0] exp, input string req);
        fetch(enc_r(5'd0, k, 5'd0));
        decode();
        check(req, mem_wdata, exp);
    endtask

    initial begin
        for (int w = 0; w < 1024; w++) mem[w] = 32'd0;
        for (int r = 0; r < 16; r++) regm[r] = 32'd0;
        mem[512] = 32'h7FFF_FFFF;
        mem[513] = 32'h8000_0000;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pc reset", pc_q, 32'd0);
        check("R1 epc reset", epc_q, 32'd0);
        check("R1 cause reset", {31'd0, cause_q}, 32'd0);
        check("R4 addr is pc", mem_addr, pc_q);
        rst_n = 1'b1;

        // Immediate loads r1..r5 through rs=r0 plus offset
        begin
            logic [15:0] imms [1:5];
            logic [31:0] p, v;
            imms[1] = 16'h0001; imms[2] = 16'hFFFF; imms[3] = 16'h7FFF;
            imms[4] = 16'h8000; imms[5] = 16'h0005;
            for (int k = 1; k <= 5; k++) begin
                p = pc_q;
                fetch(enc_i(6'h08, 5'd0, 5'(k), imms[k]));
                check("R2 pc plus four", pc_q, p + 32'd4);
                check("R2 opcode field", {26'd0, opcode}, 32'h08);
                decode();
                peek_aluout(v);
                check("R3 speculative target", v, p + 32'd4 + (sx(imms[k]) << 2));
                exec_imm();
                peek_aluout(v);
                check("R9 register plus offset", v, sx(imms[k]));
                writeback(1'b0, 1'b0);
                regm[k] = sx(imms[k]);
            end
        end

        // Loads r6, r7 from memory
        for (int k = 6; k <= 7; k++) begin
            fetch(enc_i(6'h23, 5'd0, 5'(k), 16'h0800 + 16'((k - 6) * 4)));
            decode();
            exec_imm();
            idle(); addr_from_alu = 1;
            #1 check("R4 load address", mem_addr, 32'h800 + 32'((k - 6) * 4));
            tick();
            writeback(1'b0, 1'b1);
            regm[k] = mem[512 + k - 6];
        end

        for (int k = 0; k <= 7; k++) read_reg(5'(k), regm[k], "R5 register readback");

        // Write to r0 is dropped
        fetch(enc_i(6'h08, 5'd0, 5'd0, 16'h0005));
        decode(); exec_imm(); writeback(1'b0, 1'b0);
        read_reg(5'd0, 32'd0, "R6 r0 stays zero");

        // ALU sweep over all register pairs and all function codes
        begin
            logic [2:0] ops [0:4];
            logic [31:0] v;
            ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    for (int o = 0; o < 5; o++) begin
                        logic [31:0] er;
                        er = ref_res(ops[o], regm[i], regm[j]);
                        fetch(enc_r(5'(i), 5'(j), 5'd8));
                        decode();
                        idle(); a_sel = 1; b_sel = 0; alu_op = ops[o];
                        #1;
                        check("R7 zero flag", {31'd0, alu_zero}, {31'd0, er == 32'd0});
                        check("R8 overflow flag", {31'd0, alu_ovf},
                              {31'd0, ref_ovf(ops[o], regm[i], regm[j])});
                        tick();
                        peek_aluout(v);
                        check("R7 alu result", v, er);
                    end
                end
            end
        end

        // Unassigned ALU code gives zero
        begin
            logic [31:0] v;
            fetch(enc_r(5'd6, 5'd5, 5'd8));
            decode();
            idle(); a_sel = 1; alu_op = 3'b011;
            tick();
            peek_aluout(v);
            check("R7 unused code", v, 32'd0);
        end

        // R-type writeback to rd field, rt untouched
        fetch(enc_r(5'd1, 5'd5, 5'd9));
        decode();
        idle(); a_sel = 1; alu_op = 3'b010; tick();
        writeback(1'b1, 1'b0);
        read_reg(5'd9, 32'd6, "R5 rd destination");
        read_reg(5'd5, 32'd5, "R5 rt untouched");

        // Store r6 to 0x808
        fetch(enc_i(6'h2B, 5'd0, 5'd6, 16'h0808));
        decode(); exec_imm();
        idle(); addr_from_alu = 1; bmem_we = 1'b1;
        #1 check("R4 store data", mem_wdata, 32'h7FFF_FFFF);
        tick();
        bmem_we = 1'b0;
        check("R4 stored word", mem[514], 32'h7FFF_FFFF);

        // Branches
        begin
            logic [31:0] p;
            logic [15:0] offs [0:2];
            logic [4:0]  rsv  [0:2];
            logic        tk   [0:2];
            offs[0] = 16'd3;    rsv[0] = 5'd5; tk[0] = 1'b1;
            offs[1] = 16'd3;    rsv[1] = 5'd1; tk[1] = 1'b0;
            offs[2] = 16'hFFFE; rsv[2] = 5'd5; tk[2] = 1'b1;
            for (int b = 0; b < 3; b++) begin
                p = pc_q;
                fetch(enc_i(6'h04, rsv[b], 5'd5, offs[b]));
                decode();
                idle(); a_sel = 1; alu_op = 3'b110; pc_sel = 1; pc_cond_we = 1;
                tick();
                check("R11 branch pc", pc_q,
                      tk[b] ? p + 32'd4 + (sx(offs[b]) << 2) : p + 32'd4);
            end
        end

        // Jumps
        fetch({6'h02, 26'h0000040});
        idle(); pc_sel = 2; pc_we = 1; tick();
        check("R10 jump target", pc_q, 32'h0000_0100);
        fetch({6'h02, 26'h3FF_FFFF});
        idle(); pc_sel = 2; pc_we = 1; tick();
        check("R10 jump target top", pc_q, 32'h0FFF_FFFC);

        // Exceptions
        begin
            logic [31:0] p;
            for (int c = 1; c >= 0; c--) begin
                p = pc_q;
                fetch(32'hFC00_0000);
                idle(); b_sel = 1; alu_op = 3'b110; epc_we = 1; cause_we = 1;
                cause_val = 1'(c); pc_sel = 3; pc_we = 1;
                tick();
                check("R10 vector pc", pc_q, 32'h0C00_0000);
                check("R12 saved pc", epc_q, p);
                check("R12 cause value", {31'd0, cause_q}, 32'(c));
            end
            idle(); cause_val = 1'b1; b_sel = 1; alu_op = 3'b010;
            tick();
            check("R12 epc held", epc_q, 32'h0C00_0000);
            check("R12 cause held", {31'd0, cause_q}, 32'd0);
            check("R11 pc held", pc_q, 32'h0C00_0000);
        end

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule